// File: doc/BRIEF.md
# Per-Core Idle State Sequencer

This block steps each of several cores into and out of idle depths C1, C3 and C6, and steps the shared uncore into a package deep state once every core is power gated. Software issues a wait instruction whose argument gives the idle depth. That arrives here as a one-cycle `idleReq` pulse with a 2-bit `idleDepth` code. A one-cycle `wakeIrq` pulse brings the core back to C0.

Each core has five controlled resources, one per step bit:

| Bit | Resource |
|-----|----------|
| 0 | pipeline halt |
| 1 | architectural state save |
| 2 | gating of most core clocks |
| 3 | gating of the remaining core clocks |
| 4 | power gate |

The package has four step bits:

| Bit | Resource |
|-----|----------|
| 0 | uncore logic stop |
| 1 | memory self-refresh |
| 2 | I/O low power |
| 3 | uncore clock grid stop |

Each step is a level request. The request is held high while the resource is in its low-power condition. The sequencer waits until the acknowledge matches the request before it takes the next step. A timeout bounds each wait. Voltage control, state storage and power switches sit behind these handshakes.

One engine is used for both the cores and the package. It walks the step bits upward on entry and downward on exit.

A wake that arrives during an entry takes effect at the next step boundary, and the unwind starts from the step just taken. A wake that arrives while the package is asleep is held until the package sequence has fully reversed.

Top module: `idle_seq_top`

## Requirements
- R1: After reset every core status and the package status read 0, and all core and package step requests are low.
- R2: An idle request with depth code 1 (C1) raises core step bits 0 and 2 only (request value 5'b00101). The core status then reads 1.
- R3: Depth code 2 (C3) raises step bits 0, 2 and 3 (5'b01101). The core status then reads 3.
- R4: Depth code 3 (C6) raises step bits 0, 1, 2, 3, 4 strictly one at a time in that order. This is halt, save, most clocks, remaining clocks, power gate. The core status then reads 6.
- R5: A wake releases the raised step bits one at a time in descending order. Each release waits for its acknowledge to fall. The status returns to 0 when the last bit is released.
- R6: Entry and exit on one core leave the step requests and status of every other core unchanged.
- R7: The package sequence starts only when every core rests in C6. It raises package bits 0, 1, 2, 3 in that order, and the package status then reads 6.
- R8: A wake to any core while the package is asleep releases package bits 3, 2, 1, 0 first. Only then does that core's power-gate request fall. The other cores stay in C6.
- R9: A wake during an entry stops the entry at the next step boundary. Steps not yet taken are never raised, and the core unwinds to status 0.
- R10: A core that rests in an idle depth stays there until a wake arrives. A wake received while the core is in C0 is discarded and does not cut short a later entry.
- R11: When an acknowledge never arrives, the step is considered complete after `TIMEOUT` cycles of waiting, and the sequence goes on.
- R12: An idle request with depth code 0 is ignored: no step bit rises and the status stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idleReq | input | NUM_CORES | One-cycle idle request per core |
| idleDepth | input | 2*NUM_CORES | Depth code per core: 0 none, 1 C1, 2 C3, 3 C6 |
| wakeIrq | input | NUM_CORES | One-cycle wake interrupt per core |
| coreStepAck | input | 5*NUM_CORES | Acknowledge per core step bit |
| coreStepReq | output | 5*NUM_CORES | Request per core step bit |
| coreState | output | 3*NUM_CORES | Core status: 0, 1, 3 or 6 |
| pkgStepAck | input | 4 | Acknowledge per package step bit |
| pkgStepReq | output | 4 | Request per package step bit |
| pkgState | output | 3 | Package status: 0 or 6 |

## Verification
The hardest situation to reach from the ports is a wake that lands in the middle of an entry, before the later steps have been taken. The bench builds this by holding back one acknowledge in its responder model. This parks the core on that step, and the wake is then delivered before the hold is released. The ordering between the package and a core wake is checked differently. Every core is first driven into C6 so that the package falls asleep. The bench then traces, cycle by cycle, the package bits falling against the woken core's power-gate bit.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;

  localparam int CORE_STEPS = 5;
  localparam int PKG_STEPS  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ENT_SET, S_ENT_WAIT, S_RES, S_EXT_CLR, S_EXT_WAIT
  } seqState_t;

  typedef struct packed {
    logic ptrClear;
    logic ptrInc;
    logic ptrDec;
    logic setCur;
    logic clrCur;
    logic timerClr;
    logic timerRun;
  } seqStrobe_t;

  // steps in use for each depth code; bit order is the entry order
  function automatic logic [CORE_STEPS-1:0] coreMaskOf(input logic [1:0] depth);
    case (depth)
      2'd1:    coreMaskOf = 5'b00101;
      2'd2:    coreMaskOf = 5'b01101;
      2'd3:    coreMaskOf = 5'b11111;
      default: coreMaskOf = 5'b00000;
    endcase
  endfunction

  function automatic logic [2:0] depthCode(input logic [1:0] depth);
    case (depth)
      2'd1:    depthCode = 3'd1;
      2'd2:    depthCode = 3'd3;
      2'd3:    depthCode = 3'd6;
      default: depthCode = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/idle_seq_dp.sv
module idle_seq_dp
  import idle_seq_pkg::*;
#(
  parameter int NSTEPS  = 5,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [NSTEPS-1:0] stepMask,
  input  logic [NSTEPS-1:0] stepAck,
  output logic [NSTEPS-1:0] stepReq,
  output logic              stepDone,
  output logic              atFirst,
  output logic              atLast
);
  localparam int PW = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(NSTEPS - 1);
  localparam logic [TW-1:0] WAIT_LIM = TW'(TIMEOUT);

  logic [PW-1:0] ptr;
  logic [TW-1:0] waitCnt;
  logic          timedOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      stepReq <= '0;
      waitCnt <= '0;
    end else begin
      if (stb.ptrClear)    ptr <= '0;
      else if (stb.ptrInc) ptr <= ptr + 1'b1;
      else if (stb.ptrDec) ptr <= ptr - 1'b1;

      if (stb.setCur)      stepReq[ptr] <= stepMask[ptr];
      else if (stb.clrCur) stepReq[ptr] <= 1'b0;

      if (stb.timerClr) waitCnt <= '0;
      else if (stb.timerRun && waitCnt != WAIT_LIM) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign timedOut = (waitCnt == WAIT_LIM);
  assign stepDone = !stepMask[ptr] || (stepAck[ptr] == stepReq[ptr]) || timedOut;
  assign atFirst  = (ptr == '0);
  assign atLast   = (ptr == LAST_IDX);

  // checker state
  logic [NSTEPS-1:0] prevReq;
  logic              orderOk;

  always_ff @(posedge clk) begin
    if (!rstN) prevReq <= '0;
    else       prevReq <= stepReq;
  end

  always_comb begin
    orderOk = 1'b1;
    for (int k = 0; k < NSTEPS; k++) begin
      if (stepReq[k] && !prevReq[k])
        for (int j = 0; j < k; j++)
          if (stepMask[j] && !stepReq[j]) orderOk = 1'b0;
      if (!stepReq[k] && prevReq[k])
        for (int j = k + 1; j < NSTEPS; j++)
          if (stepReq[j]) orderOk = 1'b0;
    end
  end

  // R4
  step_order_chk: assert property (@(posedge clk) disable iff (!rstN) orderOk);

  // R5
  single_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stepReq ^ prevReq) <= 1);

endmodule

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import idle_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       wake,
  input  logic       allowExit,
  input  logic       stepDone,
  input  logic       atFirst,
  input  logic       atLast,
  output seqStrobe_t stb,
  output logic       isIdle,
  output logic       isResident
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (go) begin
        stb.ptrClear = 1'b1;
        stb.timerClr = 1'b1;
        nextState    = S_ENT_SET;
      end
      S_ENT_SET: begin
        stb.setCur   = 1'b1;
        stb.timerClr = 1'b1;
        nextState    = S_ENT_WAIT;
      end
      S_ENT_WAIT: begin
        stb.timerRun = 1'b1;
        if (stepDone) begin
          if (wake && allowExit) nextState = S_EXT_CLR;
          else if (atLast)       nextState = S_RES;
          else begin
            stb.ptrInc = 1'b1;
            nextState  = S_ENT_SET;
          end
        end
      end
      S_RES: if (wake && allowExit) nextState = S_EXT_CLR;
      S_EXT_CLR: begin
        stb.clrCur   = 1'b1;
        stb.timerClr = 1'b1;
        nextState    = S_EXT_WAIT;
      end
      S_EXT_WAIT: begin
        stb.timerRun = 1'b1;
        if (stepDone) begin
          if (atFirst) nextState = S_IDLE;
          else begin
            stb.ptrDec = 1'b1;
            nextState  = S_EXT_CLR;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign isIdle     = (state == S_IDLE);
  assign isResident = (state == S_RES);

  // R10
  resident_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RES && !wake) |=> (state == S_RES));

endmodule

// File: rtl/idle_core_unit.sv
module idle_core_unit
  import idle_seq_pkg::*;
#(
  parameter int TIMEOUT = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  idleReq,
  input  logic [1:0]            idleDepth,
  input  logic                  wakeIrq,
  input  logic                  allowExit,
  input  logic [CORE_STEPS-1:0] stepAck,
  output logic [CORE_STEPS-1:0] stepReq,
  output logic [2:0]            status,
  output logic                  inC6,
  output logic                  wakePending
);
  seqStrobe_t stb;
  logic       isIdle, isResident, stepDone, atFirst, atLast, accept;
  logic [1:0] depthReg;
  logic [2:0] statusReg;

  assign accept = isIdle && idleReq && (idleDepth != 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depthReg    <= 2'd0;
      wakePending <= 1'b0;
      statusReg   <= 3'd0;
    end else begin
      if (accept) depthReg <= idleDepth;
      wakePending <= isIdle ? 1'b0 : (wakePending | wakeIrq);
      if (isResident)  statusReg <= depthCode(depthReg);
      else if (isIdle) statusReg <= 3'd0;
    end
  end

  idle_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .go(accept), .wake(wakePending),
    .allowExit(allowExit), .stepDone(stepDone), .atFirst(atFirst),
    .atLast(atLast), .stb(stb), .isIdle(isIdle), .isResident(isResident)
  );

  idle_seq_dp #(.NSTEPS(CORE_STEPS), .TIMEOUT(TIMEOUT)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .stepMask(coreMaskOf(depthReg)),
    .stepAck(stepAck), .stepReq(stepReq), .stepDone(stepDone),
    .atFirst(atFirst), .atLast(atLast)
  );

  assign status = statusReg;
  assign inC6   = isResident && (depthReg == 2'd3);

  // R2
  status_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusReg == 3'd0 || statusReg == 3'd1 || statusReg == 3'd3 || statusReg == 3'd6);

endmodule

// File: rtl/idle_seq_top.sv
module idle_seq_top
  import idle_seq_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int TIMEOUT   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CORES-1:0]          idleReq,
  input  logic [2*NUM_CORES-1:0]        idleDepth,
  input  logic [NUM_CORES-1:0]          wakeIrq,
  input  logic [CORE_STEPS*NUM_CORES-1:0] coreStepAck,
  output logic [CORE_STEPS*NUM_CORES-1:0] coreStepReq,
  output logic [3*NUM_CORES-1:0]        coreState,
  input  logic [PKG_STEPS-1:0]          pkgStepAck,
  output logic [PKG_STEPS-1:0]          pkgStepReq,
  output logic [2:0]                    pkgState
);
  localparam logic [PKG_STEPS-1:0] PKG_MASK = '1;

  logic [NUM_CORES-1:0] coreInC6, corePending;
  logic       pkgIdle, pkgResident, pkgDone, pkgFirst, pkgLast, pkgGo;
  seqStrobe_t pkgStb;
  logic [2:0] pkgStateReg;

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    idle_core_unit #(.TIMEOUT(TIMEOUT)) core_i (
      .clk(clk), .rstN(rstN), .idleReq(idleReq[c]),
      .idleDepth(idleDepth[2*c +: 2]), .wakeIrq(wakeIrq[c]),
      .allowExit(pkgIdle),
      .stepAck(coreStepAck[CORE_STEPS*c +: CORE_STEPS]),
      .stepReq(coreStepReq[CORE_STEPS*c +: CORE_STEPS]),
      .status(coreState[3*c +: 3]), .inC6(coreInC6[c]),
      .wakePending(corePending[c])
    );

    // R8
    core_after_pkg_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(coreStepReq[CORE_STEPS*c + CORE_STEPS - 1]) |-> (pkgStepReq == '0));
  end

  assign pkgGo = (&coreInC6) && !(|corePending);

  idle_seq_ctrl pkgCtrl_i (
    .clk(clk), .rstN(rstN), .go(pkgGo), .wake(|corePending),
    .allowExit(1'b1), .stepDone(pkgDone), .atFirst(pkgFirst),
    .atLast(pkgLast), .stb(pkgStb), .isIdle(pkgIdle), .isResident(pkgResident)
  );

  idle_seq_dp #(.NSTEPS(PKG_STEPS), .TIMEOUT(TIMEOUT)) pkgDp_i (
    .clk(clk), .rstN(rstN), .stb(pkgStb), .stepMask(PKG_MASK),
    .stepAck(pkgStepAck), .stepReq(pkgStepReq), .stepDone(pkgDone),
    .atFirst(pkgFirst), .atLast(pkgLast)
  );

  always_ff @(posedge clk) begin
    if (!rstN)            pkgStateReg <= 3'd0;
    else if (pkgResident) pkgStateReg <= 3'd6;
    else if (pkgIdle)     pkgStateReg <= 3'd0;
  end
  assign pkgState = pkgStateReg;

  logic allCoresC6;
  always_comb begin
    allCoresC6 = 1'b1;
    for (int c = 0; c < NUM_CORES; c++)
      if (coreState[3*c +: 3] != 3'd6) allCoresC6 = 1'b0;
  end

  // R7
  pkg_needs_c6_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pkgStepReq != '0) |-> allCoresC6);

endmodule

// File: tb/idle_seq_top_tb_top.sv
module idle_seq_top_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NC = 2;
  localparam int TO = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NC-1:0]   idleReq = '0;
  logic [2*NC-1:0] idleDepth = '0;
  logic [NC-1:0]   wakeIrq = '0;
  logic [5*NC-1:0] coreStepAck, coreStepReq;
  logic [3*NC-1:0] coreState;
  logic [3:0]      pkgStepAck, pkgStepReq;
  logic [2:0]      pkgState;
  logic [5*NC-1:0] coreStall = '0;
  logic [3:0]      pkgStall = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  idle_seq_top #(.NUM_CORES(NC), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .idleDepth(idleDepth),
    .wakeIrq(wakeIrq), .coreStepAck(coreStepAck), .coreStepReq(coreStepReq),
    .coreState(coreState), .pkgStepAck(pkgStepAck), .pkgStepReq(pkgStepReq),
    .pkgState(pkgState)
  );

  // resource model: acknowledge follows request one cycle later unless stalled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      coreStepAck <= '0;
      pkgStepAck  <= '0;
    end else begin
      coreStepAck <= (coreStepReq & ~coreStall) | (coreStepAck & coreStall);
      pkgStepAck  <= (pkgStepReq & ~pkgStall) | (pkgStepAck & pkgStall);
    end
  end

  function automatic logic [4:0] reqOf(input int c);
    return coreStepReq[5*c +: 5];
  endfunction

  function automatic int stOf(input int c);
    return int'(coreState[3*c +: 3]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulseIdle(input int c, input logic [1:0] d);
    @(negedge clk);
    idleReq[c] = 1'b1;
    idleDepth[2*c +: 2] = d;
    @(negedge clk);
    idleReq[c] = 1'b0;
  endtask

  task automatic pulseWake(input int c);
    @(negedge clk);
    wakeIrq[c] = 1'b1;
    @(negedge clk);
    wakeIrq[c] = 1'b0;
  endtask

  task automatic waitState(input int c, input int code);
    for (int i = 0; i < 400; i++) begin
      if (stOf(c) == code) break;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic testReset();
    chk(coreState == '0, "R1 core status after reset", int'(coreState), 0);
    chk(coreStepReq == '0, "R1 core requests after reset", int'(coreStepReq), 0);
    chk(pkgStepReq == '0 && pkgState == 3'd0, "R1 package after reset", int'(pkgStepReq), 0);
  endtask

  task automatic testC1();
    pulseIdle(0, 2'd1);
    waitState(0, 1);
    chk(stOf(0) == 1, "R2 C1 status", stOf(0), 1);
    chk(reqOf(0) == 5'b00101, "R2 C1 step bits", int'(reqOf(0)), 5);
    chk(reqOf(1) == 5'b0 && stOf(1) == 0, "R6 other core untouched by C1", int'(reqOf(1)), 0);
    pulseWake(0);
    waitState(0, 0);
    chk(reqOf(0) == 5'b0 && stOf(0) == 0, "R5 C1 exit", int'(reqOf(0)), 0);
  endtask

  task automatic testC3();
    pulseIdle(1, 2'd2);
    waitState(1, 3);
    chk(stOf(1) == 3, "R3 C3 status", stOf(1), 3);
    chk(reqOf(1) == 5'b01101, "R3 C3 step bits", int'(reqOf(1)), 13);
    pulseWake(1);
    waitState(1, 0);
    chk(reqOf(1) == 5'b0, "R5 C3 exit", int'(reqOf(1)), 0);
  endtask

  task automatic testC6Order();
    logic [4:0] prev, cur;
    int seq;
    pulseIdle(0, 2'd3);
    prev = reqOf(0);
    seq = 0;
    for (int i = 0; i < 300 && stOf(0) != 6; i++) begin
      @(negedge clk);
      cur = reqOf(0);
      for (int k = 0; k < 5; k++) if (cur[k] && !prev[k]) seq = seq * 10 + k + 1;
      prev = cur;
    end
    chk(seq == 12345, "R4 C6 entry order", seq, 12345);
    chk(stOf(0) == 6, "R4 C6 status", stOf(0), 6);
    pulseWake(0);
    prev = reqOf(0);
    seq = 0;
    for (int i = 0; i < 300 && reqOf(0) != 0; i++) begin
      @(negedge clk);
      cur = reqOf(0);
      for (int k = 0; k < 5; k++) if (!cur[k] && prev[k]) seq = seq * 10 + k + 1;
      prev = cur;
    end
    chk(seq == 54321, "R5 C6 exit order", seq, 54321);
    waitState(0, 0);
    chk(stOf(0) == 0, "R5 status back to C0", stOf(0), 0);
  endtask

  task automatic testIndependence();
    int bad;
    pulseIdle(0, 2'd3);
    waitState(0, 6);
    bad = 0;
    pulseIdle(1, 2'd1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (reqOf(0) != 5'b11111 || stOf(0) != 6) bad++;
    end
    pulseWake(1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (reqOf(0) != 5'b11111 || stOf(0) != 6) bad++;
    end
    chk(bad == 0, "R6 core0 undisturbed by core1", bad, 0);
    chk(stOf(1) == 0, "R6 core1 back in C0", stOf(1), 0);
  endtask

  task automatic testPackage();
    logic [3:0] pPrev, pCur;
    logic [4:0] cPrev, cCur;
    int seq, viol;
    pulseIdle(1, 2'd3);
    pPrev = pkgStepReq;
    seq = 0;
    for (int i = 0; i < 400 && pkgState != 3'd6; i++) begin
      @(negedge clk);
      pCur = pkgStepReq;
      for (int k = 0; k < 4; k++) if (pCur[k] && !pPrev[k]) seq = seq * 10 + k + 1;
      pPrev = pCur;
    end
    chk(seq == 1234, "R7 package entry order", seq, 1234);
    chk(pkgStepReq == 4'hF && pkgState == 3'd6, "R7 package asleep", int'(pkgState), 6);
    pulseWake(1);
    pPrev = pkgStepReq;
    cPrev = reqOf(1);
    seq = 0;
    viol = 0;
    for (int i = 0; i < 400 && stOf(1) != 0; i++) begin
      @(negedge clk);
      pCur = pkgStepReq;
      cCur = reqOf(1);
      for (int k = 0; k < 4; k++) if (!pCur[k] && pPrev[k]) seq = seq * 10 + k + 1;
      if (cPrev[4] && !cCur[4] && pCur != 4'h0) viol++;
      pPrev = pCur;
      cPrev = cCur;
    end
    chk(seq == 4321, "R8 package exit order", seq, 4321);
    chk(viol == 0, "R8 core woke before package", viol, 0);
    chk(stOf(0) == 6 && reqOf(0) == 5'b11111, "R8 other core stays in C6", stOf(0), 6);
    chk(pkgState == 3'd0, "R8 package status awake", int'(pkgState), 0);
    pulseWake(0);
    waitState(0, 0);
  endtask

  task automatic testAbort();
    logic [4:0] seen;
    int sawSix;
    coreStall[2] = 1'b1;
    pulseIdle(0, 2'd3);
    repeat (4) @(negedge clk);
    pulseWake(0);
    coreStall[2] = 1'b0;
    seen = '0;
    sawSix = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      seen = seen | reqOf(0);
      if (stOf(0) == 6) sawSix++;
    end
    chk(seen[4:3] == 2'b00, "R9 later steps never raised", int'(seen[4:3]), 0);
    chk(sawSix == 0, "R9 never reached C6", sawSix, 0);
    chk(reqOf(0) == 5'b0 && stOf(0) == 0, "R9 unwound to C0", int'(reqOf(0)), 0);
    pulseIdle(0, 2'd1);
    waitState(0, 1);
    repeat (12) @(negedge clk);
    chk(stOf(0) == 1, "R10 stale wake does not cut later entry", stOf(0), 1);
    pulseWake(0);
    waitState(0, 0);
  endtask

  task automatic testTimeout();
    coreStall[8] = 1'b1;
    pulseIdle(1, 2'd2);
    for (int i = 0; i < 100 && !reqOf(1)[3]; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(stOf(1) == 0, "R11 still waiting on stalled step", stOf(1), 0);
    repeat (20) @(negedge clk);
    chk(stOf(1) == 3, "R11 step completes after timeout", stOf(1), 3);
    chk(reqOf(1) == 5'b01101, "R11 requests after timeout", int'(reqOf(1)), 13);
    coreStall[8] = 1'b0;
    pulseWake(1);
    waitState(1, 0);
  endtask

  task automatic testIgnored();
    pulseIdle(0, 2'd0);
    repeat (10) @(negedge clk);
    chk(stOf(0) == 0 && reqOf(0) == 5'b0, "R12 depth 0 ignored", int'(reqOf(0)), 0);
    pulseWake(1);
    pulseIdle(1, 2'd1);
    waitState(1, 1);
    repeat (12) @(negedge clk);
    chk(stOf(1) == 1, "R10 wake in C0 discarded", stOf(1), 1);
    pulseWake(1);
    waitState(1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testC1();
    testC3();
    testC6Order();
    testIndependence();
    testPackage();
    testAbort();
    testTimeout();
    testIgnored();
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule